// File: doc/BRIEF.md
# Dual Wiper Position Bank with Nonvolatile Shadow

This block holds the working tap positions of two digital potentiometer channels. Each channel also has a shadow copy that models nonvolatile storage. A command decoder in front of the block passes decoded requests over a valid/ready port. Each request carries read or write, a channel code, a volatile or nonvolatile flag and a data byte. Read results come back on a separate valid/ready response port. Channel one has 100 taps and drives a one-hot tap select. Channel two has 256 taps and drives a binary position.

While `por_hold` is high, the working registers sit at their pre-recall values. On the first cycle after `por_hold` falls, both working registers load their shadow copies. Three plain control inputs gate the writes: the write-enable latch bit, the write-protect pin and the wiper lock bit. A nonvolatile write that is allowed starts a busy window of `BUSY_CYCLES` cycles, and no request is accepted during it.

Back-pressure: `req_ready` is low while `por_hold` is high, during the recall cycle, while busy, and while a read response is still waiting. A request is accepted on a rising edge where both `req_valid` and `req_ready` are high. A write that is accepted but not allowed is dropped without any effect. `rsp_valid` stays high, and `rsp_data` stays constant, until a rising edge where `rsp_ready` is high.

Top module: `wiper_bank`

## Requirements
- R1: After reset, and on every cycle while `por_hold` is high, channel one is at tap 0, channel two is at 255 and `req_ready` is low.
- R2: On the edge where `por_hold` is first sampled low, each working register loads its shadow copy. After reset the shadow copies are 0. `req_ready` is high from the next cycle on.
- R3: An allowed volatile write (`req_nv`=0) changes only the working register. The next recall restores the shadow value.
- R4: An allowed nonvolatile write (`req_nv`=1) updates both the working register and the shadow copy with the same value.
- R5: Write data above a channel's highest tap sets that channel to its highest tap: 99 for channel one and 255 for channel two. The value never wraps.
- R6: Channel codes: `req_chan`=2'b01 selects channel one and 2'b10 selects channel two. The codes 2'b00 and 2'b11 are reserved. Writes to a reserved code have no effect, and reads from one return 8'h00.
- R7: When `wel` is 0, every write is accepted and ignored.
- R8: When `wp_pin` is 1, nonvolatile writes are ignored. When both `wp_pin` and `wlock` are 1, volatile writes are ignored as well. A write that is ignored does not start a busy window.
- R9: An allowed nonvolatile write holds `busy` high for exactly `BUSY_CYCLES` cycles after the accepting edge. `req_ready` is low throughout that window.
- R10: A read response appears on the cycle after acceptance and carries the selected working value. It stays valid and stable until `rsp_ready` is seen high.
- R11: `wiper1_sel` is one-hot, with bit N high for tap N. `wiper2_pos` is the binary tap number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_hold | input | 1 | High while the reset interval runs; its fall triggers recall |
| wel | input | 1 | Write-enable latch bit |
| wp_pin | input | 1 | Write-protect pin |
| wlock | input | 1 | Wiper lock bit |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_nv | input | 1 | 1 = nonvolatile write |
| req_chan | input | 2 | Channel code (R6) |
| req_data | input | DW | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | DW | Read response data |
| busy | output | 1 | Nonvolatile busy window active |
| wiper1_sel | output | CH1_TAPS | Channel one one-hot tap select |
| wiper2_pos | output | DW | Channel two binary tap |

## Verification
Each write changes the wiper outputs one register stage after its accepting edge. The bench therefore samples on the falling edge that follows acceptance. A read response is due at that same falling edge. The recall is visible one falling edge after `por_hold` is released, and the forced values one falling edge after it is raised. The busy window is measured by counting the falling edges on which `busy` is high and comparing the count with `BUSY_CYCLES`. The bench drives every input on a falling edge so that nothing races the rising edge.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [1:0] {
    CH_NONE = 2'b00,
    CH_ONE  = 2'b01,
    CH_TWO  = 2'b10,
    CH_RSVD = 2'b11
  } chan_e;
endpackage

// File: rtl/wb_gate.sv
module wb_gate (
  input  logic       fire,
  input  logic       is_write,
  input  logic       nv,
  input  logic [1:0] chan,
  input  logic       wel,
  input  logic       wp_pin,
  input  logic       wlock,
  output logic       wr1,
  output logic       wr2,
  output logic       nv_start
);
  import wb_pkg::*;
  logic allow;
  logic any;

  always_comb begin
    // nonvolatile needs the pin low; volatile is blocked only with pin and lock
    allow    = wel && (nv ? !wp_pin : !(wp_pin && wlock));
    any      = fire && is_write && allow;
    wr1      = any && (chan_e'(chan) == CH_ONE);
    wr2      = any && (chan_e'(chan) == CH_TWO);
    nv_start = (wr1 || wr2) && nv;
  end
endmodule

// File: rtl/wb_busy.sv
module wb_busy #(
  parameter int CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy_o
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(CYC);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign busy_o = (cnt != '0);
endmodule

// File: rtl/wb_chan.sv
module wb_chan #(
  parameter int TAPS   = 100,
  parameter int DW     = 8,
  parameter int INIT   = 0,
  parameter bit ONEHOT = 1'b1,
  localparam int SELW  = ONEHOT ? TAPS : DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          recall,
  input  logic          wr_en,
  input  logic          wr_nv,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] work_o,
  output logic [SELW-1:0] sel_o
);
  localparam int MAXV = TAPS - 1;
  logic [DW-1:0] work, shadow, clamped;

  always_comb clamped = (int'(wr_data) > MAXV) ? DW'(MAXV) : wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work   <= DW'(INIT);
      shadow <= '0;
    end else begin
      if (hold)        work <= DW'(INIT);
      else if (recall) work <= shadow;
      else if (wr_en)  work <= clamped;
      if (wr_en && wr_nv) shadow <= clamped;
    end
  end

  assign work_o = work;

  generate
    if (ONEHOT) begin : g_onehot
      for (genvar g = 0; g < TAPS; g++) begin : g_tap
        assign sel_o[g] = (int'(work) == g);
      end
    end else begin : g_binary
      assign sel_o = work;
    end
  endgenerate
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank #(
  parameter int CH1_TAPS    = 100,
  parameter int CH2_TAPS    = 256,
  parameter int DW          = 8,
  parameter int BUSY_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                por_hold,
  input  logic                wel,
  input  logic                wp_pin,
  input  logic                wlock,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic                req_nv,
  input  logic [1:0]          req_chan,
  input  logic [DW-1:0]       req_data,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DW-1:0]       rsp_data,
  output logic                busy,
  output logic [CH1_TAPS-1:0] wiper1_sel,
  output logic [DW-1:0]       wiper2_pos
);
  import wb_pkg::*;

  logic          por_q, recall, fire;
  logic          wr1, wr2, nv_start;
  logic [DW-1:0] w1, w2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) por_q <= 1'b1;
    else        por_q <= por_hold;
  end

  assign recall    = por_q && !por_hold;
  assign req_ready = !por_q && !por_hold && !busy && !rsp_valid;
  assign fire      = req_valid && req_ready;

  wb_gate u_gate (
    .fire(fire), .is_write(req_write), .nv(req_nv), .chan(req_chan),
    .wel(wel), .wp_pin(wp_pin), .wlock(wlock),
    .wr1(wr1), .wr2(wr2), .nv_start(nv_start)
  );

  wb_busy #(.CYC(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(nv_start), .busy_o(busy)
  );

  wb_chan #(.TAPS(CH1_TAPS), .DW(DW), .INIT(0), .ONEHOT(1'b1)) u_ch1 (
    .clk(clk), .rst_n(rst_n), .hold(por_hold), .recall(recall),
    .wr_en(wr1), .wr_nv(req_nv), .wr_data(req_data),
    .work_o(w1), .sel_o(wiper1_sel)
  );

  wb_chan #(.TAPS(CH2_TAPS), .DW(DW), .INIT(CH2_TAPS - 1), .ONEHOT(1'b0)) u_ch2 (
    .clk(clk), .rst_n(rst_n), .hold(por_hold), .recall(recall),
    .wr_en(wr2), .wr_nv(req_nv), .wr_data(req_data),
    .work_o(w2), .sel_o(wiper2_pos)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (fire && !req_write) begin
      rsp_valid <= 1'b1;
      unique case (chan_e'(req_chan))
        CH_ONE:  rsp_data <= w1;
        CH_TWO:  rsp_data <= w2;
        default: rsp_data <= '0;
      endcase
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/wiper_bank_chk.sv
module wiper_bank_chk #(
  parameter int CH1_TAPS = 100,
  parameter int CH2_TAPS = 256,
  parameter int DW       = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                por_hold,
  input logic                wel,
  input logic                wp_pin,
  input logic                wlock,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_write,
  input logic                req_nv,
  input logic [1:0]          req_chan,
  input logic [DW-1:0]       req_data,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [DW-1:0]       rsp_data,
  input logic                busy,
  input logic [CH1_TAPS-1:0] wiper1_sel,
  input logic [DW-1:0]       wiper2_pos
);
  logic acc_wr;
  assign acc_wr = req_valid && req_ready && req_write;

  // R1
  hold_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_hold |=> (wiper2_pos == DW'(CH2_TAPS - 1)) && wiper1_sel[0]);

  // R5
  clamp_ch1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr && !req_nv && wel && !(wp_pin && wlock) && (req_chan == 2'b01)
    && (int'(req_data) >= CH1_TAPS) |=> wiper1_sel[CH1_TAPS-1]);

  // R7
  wel_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr && !wel |=> $stable(wiper1_sel) && $stable(wiper2_pos));

  // R9
  nv_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr && req_nv && wel && !wp_pin && (req_chan == 2'b01 || req_chan == 2'b10)
    |=> busy);

  // R9
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R11
  onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wiper1_sel) == 1);
endmodule

bind wiper_bank wiper_bank_chk #(.CH1_TAPS(CH1_TAPS), .CH2_TAPS(CH2_TAPS), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .por_hold(por_hold), .wel(wel), .wp_pin(wp_pin),
  .wlock(wlock), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_nv(req_nv), .req_chan(req_chan),
  .req_data(req_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .busy(busy), .wiper1_sel(wiper1_sel),
  .wiper2_pos(wiper2_pos)
);

// File: tb/wiper_bank_tb_top.sv
`timescale 1ns/1ps
module wiper_bank_tb_top;
  localparam int BUSY = 16;
  localparam int T1   = 100;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, por_hold, wel, wp_pin, wlock;
  logic req_valid, req_ready, req_write, req_nv, rsp_valid, rsp_ready, busy;
  logic [1:0] req_chan;
  logic [7:0] req_data, rsp_data, wiper2_pos;
  logic [T1-1:0] wiper1_sel;

  int n_chk = 0, n_err = 0;
  int e1w = 0, e1s = 0, e2w = 255, e2s = 0;

  wiper_bank #(.CH1_TAPS(T1), .CH2_TAPS(256), .DW(8), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .por_hold(por_hold), .wel(wel), .wp_pin(wp_pin),
    .wlock(wlock), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_nv(req_nv), .req_chan(req_chan),
    .req_data(req_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .busy(busy), .wiper1_sel(wiper1_sel),
    .wiper2_pos(wiper2_pos)
  );

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // index of the single high bit, -1 if not exactly one
  function automatic int w1_idx();
    int idx = -1, cnt = 0;
    for (int i = 0; i < T1; i++) if (wiper1_sel[i]) begin idx = i; cnt++; end
    return (cnt == 1) ? idx : -1;
  endfunction

  function automatic int clamp1(int d);
    return (d > T1 - 1) ? T1 - 1 : d;
  endfunction

  task automatic req(bit wr, bit nv, logic [1:0] ch, logic [7:0] d);
    @(negedge clk);
    req_write = wr; req_nv = nv; req_chan = ch; req_data = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(logic [1:0] ch, int exp, string rq);
    req(1'b0, 1'b0, ch, 8'h00);
    chk({rq, " rsp_valid"}, rsp_valid, 1);
    chk({rq, " rsp_data"}, rsp_data, exp);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk({rq, " rsp cleared"}, rsp_valid, 0);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic power_cycle(string rq);
    @(negedge clk);
    por_hold = 1'b1;
    @(negedge clk);
    chk("R1 hold ch1", w1_idx(), 0);
    chk("R1 hold ch2", wiper2_pos, 255);
    chk("R1 hold ready", req_ready, 0);
    por_hold = 1'b0;
    @(negedge clk);
    e1w = e1s; e2w = e2s;
    chk({rq, " recall ch1"}, w1_idx(), e1w);
    chk({rq, " recall ch2"}, wiper2_pos, e2w);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(200000 * 5);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; por_hold = 1'b1; wel = 1'b0; wp_pin = 1'b0; wlock = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_nv = 1'b0; req_chan = 2'b00;
    req_data = 8'h00; rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset and hold state
    chk("R1 ch1 init", w1_idx(), 0);
    chk("R1 ch2 init", wiper2_pos, 255);
    chk("R1 ready low", req_ready, 0);
    chk("R1 busy low", busy, 0);
    chk("R1 rsp low", rsp_valid, 0);
    por_hold = 1'b0;
    @(negedge clk);
    // R2 recall of default shadows
    e2w = 0;
    chk("R2 ch1 recall", w1_idx(), 0);
    chk("R2 ch2 recall", wiper2_pos, 0);
    chk("R2 ready", req_ready, 1);

    wel = 1'b1;
    // R5 R11 channel one sweep, volatile
    for (int d = 0; d < 256; d++) begin
      req(1'b1, 1'b0, 2'b01, 8'(d));
      e1w = clamp1(d);
      chk("R5 R11 ch1 tap", w1_idx(), e1w);
      if (d % 37 == 0) rd(2'b01, e1w, "R10 ch1 read");
    end
    // R11 channel two sweep, volatile, with reads
    for (int d = 0; d < 256; d++) begin
      req(1'b1, 1'b0, 2'b10, 8'(d));
      e2w = d;
      chk("R11 ch2 pos", wiper2_pos, e2w);
      rd(2'b10, e2w, "R10 ch2 read");
    end
    // R3 volatile writes left shadows alone
    power_cycle("R3");

    // R4 R9 nonvolatile write with clamp
    req(1'b1, 1'b1, 2'b01, 8'd150);
    e1w = 99; e1s = 99;
    chk("R5 nv clamp ch1", w1_idx(), 99);
    chk("R9 ready low in busy", req_ready, 0);
    begin
      int c = 0;
      while (busy) begin c++; @(negedge clk); end
      chk("R9 busy length", c, BUSY);
    end
    req(1'b1, 1'b1, 2'b10, 8'hA5);
    e2w = 8'hA5; e2s = 8'hA5;
    wait_idle();
    power_cycle("R4");
    req(1'b1, 1'b0, 2'b10, 8'd3);
    chk("R3 vol ch2", wiper2_pos, 3);
    power_cycle("R3 restore");

    // R6 reserved codes
    req(1'b1, 1'b0, 2'b00, 8'd7);
    req(1'b1, 1'b1, 2'b11, 8'd7);
    chk("R6 rsvd busy", busy, 0);
    chk("R6 rsvd ch1", w1_idx(), e1w);
    chk("R6 rsvd ch2", wiper2_pos, e2w);
    rd(2'b11, 0, "R6 rsvd read");
    rd(2'b00, 0, "R6 none read");

    // R7 R8 permission sweep on channel two
    for (int k = 0; k < 16; k++) begin
      bit kw = k[0], kp = k[1], kl = k[2], kn = k[3];
      bit ok = kw && (kn ? !kp : !(kp && kl));
      @(negedge clk);
      wel = kw; wp_pin = kp; wlock = kl;
      req(1'b1, kn, 2'b10, 8'(8'h30 + k));
      if (ok) e2w = 8'h30 + k;
      if (ok && kn) e2s = 8'h30 + k;
      chk(kw ? "R8 gate ch2" : "R7 wel ch2", wiper2_pos, e2w);
      chk("R8 busy start", busy, int'(ok && kn));
      wait_idle();
    end
    wel = 1'b1; wp_pin = 1'b0; wlock = 1'b0;
    power_cycle("R8 shadow");

    // R10 response held under back-pressure
    req(1'b0, 1'b0, 2'b10, 8'h00);
    for (int i = 0; i < 3; i++) begin
      chk("R10 held valid", rsp_valid, 1);
      chk("R10 held data", rsp_data, e2w);
      chk("R10 ready low", req_ready, 0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R10 released", rsp_valid, 0);

    summary();
    $finish;
  end
endmodule